// File: doc/BRIEF.md
# Cascadable serial configuration memory

This block is a bit-serial read-only store. It holds a fixed bit pattern, set by a parameter, and feeds it out one bit per clock on a single data line. An internal address counter selects the bit on show. Each rising clock edge moves the counter on by one, but only while the device is selected and out of reset. A consumer, such as a configuration engine, samples the line before each rising edge.

Several devices can hold one bitstream that is longer than any single device. They share the clock and the data line. Each device's cascade output feeds the enable input of the next device. A device drives the line only while it is selected and has bits left to send. At all other times it releases the line to high impedance.

A single combined reset/output-enable pin clears the counter and releases the line. A parameter sets whether a high level or a low level asserts this pin.

Top module: `scfg_rom`

## Requirements
- R1: While the reset/output-enable pin is asserted, the block behaves as follows, with no wait for a clock edge:
  - the address counter is zero;
  - `casc_o` is low;
  - `data_o` is high impedance.
- R2: With `RST_ACTIVE_HIGH` = 1, a high level on `rst_oe_i` asserts reset. With `RST_ACTIVE_HIGH` = 0, a low level asserts it.
- R3: While `en_i` is high, reset is released and the device is not exhausted, `data_o` shows bit `INIT[addr]`. Bit 0 of `INIT` is the first bit sent, and it is on the line as soon as reset is released.
- R4: A rising clock edge advances the address by exactly one when `en_i` is high, reset is released and the address is below `DEPTH-1`.
- R5: While `en_i` is low, `data_o` is high impedance and the address holds. When `en_i` goes high again, output resumes at the bit where it stopped.
- R6: The rising edge that is taken at address `DEPTH-1` with `en_i` high has these effects:
  - `casc_o` goes high, and it stays high until reset is asserted;
  - from then on, `data_o` stays high impedance and the address no longer moves.
- R7: Two devices share one clock and one data line, with `casc_o` of the first device driving `en_i` of the second. Together they send all `DEPTH` bits of the first device's pattern, then all bits of the second's, in order, with no gap and no overlap.
- R8: After the device is exhausted, asserting and then releasing reset restarts output from bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Serial clock; the counter steps on its rising edge |
| rst_oe_i | input | 1 | Combined reset/output-enable; its active level is set by `RST_ACTIVE_HIGH`; asynchronous |
| en_i | input | 1 | Chip enable, active high; fed from the previous device's `casc_o` in a chain |
| data_o | output | 1 | Serial data bit; high impedance when the device is not driving |
| casc_o | output | 1 | Cascade enable for the next device; high once all bits have been sent |

## Verification
The bench builds two chains of two devices each, with `DEPTH` = 16. One chain sets `RST_ACTIVE_HIGH` = 0 and the other sets it to 1, and the two devices in each chain hold different patterns. The bench reads each shared line through a weak pull: a pull-up on one chain and a pull-down on the other, so a released line reads as a known level. The small depth means a few dozen cycles reach the terminal count, the hand-off between devices, a pause partway through the stream, and an asynchronous reset issued after the chain is exhausted, under both reset polarities.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
  // Translate the combined pin into an active-low internal reset.
  function automatic logic pin_to_rst_n(input logic pin, input bit active_high);
    return active_high ? ~pin : pin;
  endfunction
endpackage

// File: rtl/scfg_addr_ctr.sv
module scfg_addr_ctr #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          tc_o
);
  localparam logic [AW-1:0] LastAddr = AW'(DEPTH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      tc_o   <= 1'b0;
    end else if (step_i && !tc_o) begin
      if (addr_o == LastAddr) tc_o <= 1'b1;  // stop on last bit, do not wrap
      else                    addr_o <= addr_o + AW'(1);
    end
  end
endmodule

// File: rtl/scfg_bit_store.sv
module scfg_bit_store #(
  parameter int               DEPTH = 64,
  parameter int               AW    = $clog2(DEPTH),
  parameter logic [DEPTH-1:0] INIT  = '0
) (
  input  logic [AW-1:0] addr_i,
  output logic          bit_o
);
  always_comb begin
    bit_o = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (addr_i == AW'(i)) bit_o = INIT[i];
    end
  end
endmodule

// File: rtl/scfg_rom.sv
module scfg_rom #(
  parameter int               DEPTH           = 64,
  parameter bit               RST_ACTIVE_HIGH = 1'b0,
  parameter logic [DEPTH-1:0] INIT            = {(DEPTH / 4){4'b1010}},
  localparam int              AW              = $clog2(DEPTH)
) (
  input  logic clk_i,
  input  logic rst_oe_i,
  input  logic en_i,
  output logic data_o,
  output logic casc_o
);
  import scfg_pkg::*;

  logic          rst_ni;
  logic [AW-1:0] addr;
  logic          tc;
  logic          cur_bit;
  logic          drive;

  assign rst_ni = pin_to_rst_n(rst_oe_i, RST_ACTIVE_HIGH);

  scfg_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (en_i),
    .addr_o (addr),
    .tc_o   (tc)
  );

  scfg_bit_store #(.DEPTH(DEPTH), .AW(AW), .INIT(INIT)) u_store (
    .addr_i (addr),
    .bit_o  (cur_bit)
  );

  assign drive  = en_i & ~tc & rst_ni;
  assign data_o = drive ? cur_bit : 1'bz;
  assign casc_o = tc;
endmodule

// File: rtl/scfg_rom_chk.sv
module scfg_rom_chk #(
  parameter int DEPTH           = 64,
  parameter int AW              = $clog2(DEPTH),
  parameter bit RST_ACTIVE_HIGH = 1'b0
) (
  input logic          clk_i,
  input logic          rst_oe_i,
  input logic          en_i,
  input logic          casc_o,
  input logic [AW-1:0] addr_i,
  input logic          drive_i
);
  import scfg_pkg::*;

  logic rst_n;
  assign rst_n = pin_to_rst_n(rst_oe_i, RST_ACTIVE_HIGH);

  assert_reset_R1: assert property (@(posedge clk_i)
    !rst_n |-> (addr_i == '0 && !casc_o && !drive_i));

  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en_i && !casc_o && addr_i != AW'(DEPTH - 1)) |=> addr_i == $past(addr_i) + AW'(1));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_i |=> $stable(addr_i));

  assert_idle_release_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_i |-> !drive_i);

  assert_tc_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en_i && addr_i == AW'(DEPTH - 1)) |=> casc_o);

  assert_casc_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    casc_o |=> casc_o);

  assert_release_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    casc_o |-> !drive_i);
endmodule

bind scfg_rom scfg_rom_chk #(
  .DEPTH(DEPTH), .AW(AW), .RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)
) u_chk (
  .clk_i    (clk_i),
  .rst_oe_i (rst_oe_i),
  .en_i     (en_i),
  .casc_o   (casc_o),
  .addr_i   (addr),
  .drive_i  (drive)
);

// File: tb/scfg_rom_tb.sv
module scfg_rom_tb;
  localparam int D = 16;
  localparam logic [D-1:0] PAT_A = 16'hC3A5;
  localparam logic [D-1:0] PAT_B = 16'h5E21;

  logic clk_i = 1'b0;
  always #5 clk_i = ~clk_i;

  logic rst_l = 1'b0;  // active-low chain, start in reset
  logic rst_h = 1'b1;  // active-high chain, start in reset
  logic en_l = 1'b0, en_h = 1'b0;
  wire  bus_l, bus_h;
  logic casc_la, casc_lb, casc_ha, casc_hb;

  // Weak pulls make a released line read as a known level.
  pullup   (bus_l);
  pulldown (bus_h);

  scfg_rom #(.DEPTH(D), .RST_ACTIVE_HIGH(1'b0), .INIT(PAT_A)) u_dut (
    .clk_i(clk_i), .rst_oe_i(rst_l), .en_i(en_l), .data_o(bus_l), .casc_o(casc_la));
  scfg_rom #(.DEPTH(D), .RST_ACTIVE_HIGH(1'b0), .INIT(PAT_B)) u_dut_b (
    .clk_i(clk_i), .rst_oe_i(rst_l), .en_i(casc_la), .data_o(bus_l), .casc_o(casc_lb));
  scfg_rom #(.DEPTH(D), .RST_ACTIVE_HIGH(1'b1), .INIT(PAT_B)) u_hi_a (
    .clk_i(clk_i), .rst_oe_i(rst_h), .en_i(en_h), .data_o(bus_h), .casc_o(casc_ha));
  scfg_rom #(.DEPTH(D), .RST_ACTIVE_HIGH(1'b1), .INIT(PAT_A)) u_hi_b (
    .clk_i(clk_i), .rst_oe_i(rst_h), .en_i(casc_ha), .data_o(bus_h), .casc_o(casc_hb));

  int    checks = 0, errors = 0;
  int    sel = 0;
  bit    done = 1'b0;
  logic  exp_q[$];
  string tag_q[$];

  function automatic logic cur_bus();
    return (sel == 0) ? bus_l : bus_h;
  endfunction
  function automatic logic idle_lvl();
    return (sel == 0) ? 1'b1 : 1'b0;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s chain=%0d actual=%b expected=%b t=%0t", tag, sel, act, exp, $time);
    end
  endtask

  task automatic set_rst(bit on);
    if (sel == 0) rst_l = on ? 1'b0 : 1'b1;
    else          rst_h = on ? 1'b1 : 1'b0;
  endtask

  task automatic set_en(logic v);
    if (sel == 0) en_l = v; else en_h = v;
  endtask

  // Driver: one cycle of stimulus plus the expected line value for it.
  task automatic drive_cycle(bit rel, logic en, logic exp, string tag);
    @(negedge clk_i);
    if (rel) set_rst(1'b0);
    set_en(en);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // Monitor: samples 2 ns after the falling edge, well before the next rise.
  always @(negedge clk_i) begin
    #2;
    if (exp_q.size() > 0) begin
      logic  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, cur_bus(), e);
    end
  end

  task automatic run_chain(int s, logic [D-1:0] pa, logic [D-1:0] pb);
    logic ca, cb;
    sel = s;
    set_rst(1'b1);
    set_en(1'b1);
    repeat (3) @(negedge clk_i);
    #2;
    ca = (s == 0) ? casc_la : casc_ha;
    cb = (s == 0) ? casc_lb : casc_hb;
    check("R1 casc first", ca, 1'b0);
    check("R1 casc second", cb, 1'b0);
    check("R1 line released", cur_bus(), idle_lvl());
    for (int i = 0; i < D; i++) begin
      if (i == 6) begin
        for (int p = 0; p < 3; p++) drive_cycle(1'b0, 1'b0, idle_lvl(), "R5 paused");
      end
      drive_cycle(i == 0, 1'b1, pa[i], (i == 0) ? "R2 first bit" : "R3 first device");
    end
    for (int i = 0; i < D; i++) drive_cycle(1'b0, 1'b1, pb[i], "R7 second device");
    for (int i = 0; i < 2; i++) drive_cycle(1'b0, 1'b1, idle_lvl(), "R6 exhausted");
    @(negedge clk_i);
    #3;
    ca = (s == 0) ? casc_la : casc_ha;
    cb = (s == 0) ? casc_lb : casc_hb;
    check("R6 casc first", ca, 1'b1);
    check("R6 casc second", cb, 1'b1);
    set_rst(1'b1);  // mid-cycle: must act without a clock edge
    #1;
    ca = (s == 0) ? casc_la : casc_ha;
    check("R1 async casc clear", ca, 1'b0);
    check("R1 async line", cur_bus(), idle_lvl());
    drive_cycle(1'b1, 1'b1, pa[0], "R8 restart bit0");
    drive_cycle(1'b0, 1'b1, pa[1], "R8 restart bit1");
    drive_cycle(1'b0, 1'b1, pa[2], "R8 restart bit2");
    repeat (2) @(negedge clk_i);
    set_rst(1'b1);
    #3;
  endtask

  initial begin
    run_chain(0, PAT_A, PAT_B);
    run_chain(1, PAT_B, PAT_A);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule